// File: doc/BRIEF.md
# Lane Symbol Encoder for a Four-Kind Character Stream

This block forms the 10-bit character for one lane of a TMDS-style display link. On every character clock it looks at a 2-bit period selector and turns one of its data inputs into a symbol. The symbol is one of four kinds: a fixed control code chosen by a 2-bit value, a balanced code for a 4-bit packet nibble, a DC-balanced video code for an 8-bit pixel byte, or a guard-band character whose value depends on the lane the encoder serves.

Video characters are built in two steps. The first step reduces transitions with an XOR or XNOR chain. The second step may invert the data, steered by a signed running-disparity count. That count lives only while video is being sent: every non-video character resets it to zero, so the first pixel after any blanking, packet or guard character is encoded from a neutral balance. The symbol is registered, so a character leaves the block one clock after its inputs are applied. Serialization and the choice of period belong to the logic around the block.

Top module: `lane_symbol_encoder`

## Requirements
- R1: An active-low asynchronous reset forces the symbol output to 1101010100 and the running disparity to zero, so the first video character after reset is encoded from zero disparity.
- R2: With period code 00 (control), control values 00, 01, 10 and 11 give the symbols 1101010100, 0010101011, 0101010100 and 1010101011.
- R3: With period code 01 (packet), nibbles 0 to 15 give in turn 1010011100, 1001100011, 1011100100, 1011100010, 0101110001, 0100011110, 0110001110, 0100111100, 1011001100, 0100111001, 0110011100, 1011000110, 1010001110, 1001110001, 0101100011, 1011000011; each of these has exactly five ones.
- R4: With period code 10 (video), the XNOR chain is used (and symbol bit 8 is 0) when the pixel byte has more than four ones, or exactly four ones with bit 0 clear. Otherwise the XOR chain is used and bit 8 is 1. Chain bit 0 equals pixel bit 0, and each higher chain bit is the previous chain bit XORed (or XNORed) with the pixel bit.
- R5: For video, let B be twice the ones in the chain's low 8 bits minus 8, and D the running disparity. When D or B is zero, bit 9 is the inverse of bit 8 and the low byte is inverted only if bit 8 is 0. When D and B have the same sign, bit 9 is 1 and the low byte is inverted. Otherwise bit 9 is 0 and the low byte is sent unchanged. In every case D then grows by twice the ones in the 10-bit symbol minus 10.
- R6: Every non-video character (period codes 00, 01, 11) sets the running disparity to zero.
- R7: With period code 11 (guard), lane index 1 gives 0100110011 and every other lane index (0, 2, 3) gives 1011001100.
- R8: The symbol for the inputs present at a rising clock edge appears on the output right after that edge and holds until the next edge.
- R9: Inputs that the selected kind does not use (pixel, nibble, control value or lane index) do not affect the symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 2 | Symbol kind: 00 control, 01 packet, 10 video, 11 guard |
| ctl_i | input | 2 | Control value for control characters |
| nib_i | input | 4 | Packet nibble for packet characters |
| pix_i | input | 8 | Pixel byte for video characters |
| lane_i | input | 2 | Lane index that selects the guard-band value |
| sym_o | output | 10 | Registered 10-bit symbol |

## Verification
The only hidden state is the running disparity. If it is wrong, the video characters show it at once, because the sign of the disparity decides bit 9 and whether the low byte is inverted. A disparity that is not cleared after a non-video character shows up on the very first pixel after the break, one clock after that pixel is applied. A drifting count can stay hidden for some characters and then appear as a wrong bit 9 several pixels later. The bench therefore compares every clock against a behavioural model over long mixed runs with many short video bursts.

// File: rtl/lse_pkg.sv
package lse_pkg;
    localparam int SYM_W  = 10;
    localparam int PIX_W  = 8;
    localparam int NIB_W  = 4;
    localparam int CTL_W  = 2;
    localparam int LANE_W = 2;
    localparam int DISP_W = 6;

    typedef enum logic [1:0] {
        PER_CTRL  = 2'b00,
        PER_PKT   = 2'b01,
        PER_VIDEO = 2'b10,
        PER_GUARD = 2'b11
    } period_e;

    localparam logic [SYM_W-1:0] CTRL_CODE0 = 10'b1101010100;
    localparam logic [SYM_W-1:0] GB_LANE1   = 10'b0100110011;
    localparam logic [SYM_W-1:0] GB_OTHER   = 10'b1011001100;

    typedef struct packed {
        logic [SYM_W-1:0]         sym;
        logic signed [DISP_W-1:0] disp;
    } enc_state_t;
endpackage

// File: rtl/lse_min_trans.sv
module lse_min_trans
    import lse_pkg::*;
#(
    parameter int W = PIX_W
) (
    input  logic [W-1:0] pix_i,
    output logic [W:0]   qm_o
);
    int  ones;
    logic use_xnor;

    always_comb begin
        ones     = $countones(pix_i);
        use_xnor = (ones > W/2) || ((ones == W/2) && !pix_i[0]);
        qm_o     = '0;
        qm_o[0]  = pix_i[0];
        for (int i = 1; i < W; i++) begin
            qm_o[i] = use_xnor ? ~(qm_o[i-1] ^ pix_i[i]) : (qm_o[i-1] ^ pix_i[i]);
        end
        qm_o[W] = !use_xnor;
    end
endmodule

// File: rtl/lse_dc_balance.sv
module lse_dc_balance
    import lse_pkg::*;
#(
    parameter int W  = PIX_W,
    parameter int DW = DISP_W
) (
    input  logic [W:0]           qm_i,
    input  logic signed [DW-1:0] disp_i,
    output logic [W+1:0]         sym_o,
    output logic signed [DW-1:0] disp_o
);
    int bal;
    int cur;
    int nxt;
    int q8;

    always_comb begin
        bal = 2 * $countones(qm_i[W-1:0]) - W;
        cur = int'(disp_i);
        q8  = qm_i[W] ? 1 : 0;
        if (cur == 0 || bal == 0) begin
            sym_o = {~qm_i[W], qm_i[W], (qm_i[W] ? qm_i[W-1:0] : ~qm_i[W-1:0])};
            nxt   = qm_i[W] ? (cur + bal) : (cur - bal);
        end else if ((cur > 0 && bal > 0) || (cur < 0 && bal < 0)) begin
            sym_o = {1'b1, qm_i[W], ~qm_i[W-1:0]};
            nxt   = cur + 2 * q8 - bal;
        end else begin
            sym_o = {1'b0, qm_i[W], qm_i[W-1:0]};
            nxt   = cur - 2 * (1 - q8) + bal;
        end
        disp_o = DW'(nxt);
    end
endmodule

// File: rtl/lse_aux_codes.sv
module lse_aux_codes
    import lse_pkg::*;
(
    input  logic [1:0]        period_i,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [SYM_W-1:0]  sym_o
);
    logic [SYM_W-1:0] ctl_sym;
    logic [SYM_W-1:0] pkt_sym;
    logic [SYM_W-1:0] gb_sym;

    always_comb begin
        unique case (ctl_i)
            2'd0:    ctl_sym = CTRL_CODE0;
            2'd1:    ctl_sym = 10'b0010101011;
            2'd2:    ctl_sym = 10'b0101010100;
            default: ctl_sym = 10'b1010101011;
        endcase
    end

    always_comb begin
        unique case (nib_i)
            4'h0:    pkt_sym = 10'b1010011100;
            4'h1:    pkt_sym = 10'b1001100011;
            4'h2:    pkt_sym = 10'b1011100100;
            4'h3:    pkt_sym = 10'b1011100010;
            4'h4:    pkt_sym = 10'b0101110001;
            4'h5:    pkt_sym = 10'b0100011110;
            4'h6:    pkt_sym = 10'b0110001110;
            4'h7:    pkt_sym = 10'b0100111100;
            4'h8:    pkt_sym = 10'b1011001100;
            4'h9:    pkt_sym = 10'b0100111001;
            4'hA:    pkt_sym = 10'b0110011100;
            4'hB:    pkt_sym = 10'b1011000110;
            4'hC:    pkt_sym = 10'b1010001110;
            4'hD:    pkt_sym = 10'b1001110001;
            4'hE:    pkt_sym = 10'b0101100011;
            default: pkt_sym = 10'b1011000011;
        endcase
    end

    always_comb gb_sym = (lane_i == LANE_W'(1)) ? GB_LANE1 : GB_OTHER;

    always_comb begin
        unique case (period_i)
            PER_PKT:   sym_o = pkt_sym;
            PER_GUARD: sym_o = gb_sym;
            default:   sym_o = ctl_sym;
        endcase
    end
endmodule

// File: rtl/lane_symbol_encoder.sv
module lane_symbol_encoder
    import lse_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        period_i,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [SYM_W-1:0]  sym_o
);
    enc_state_t st_d, st_q;

    logic [PIX_W:0]           qm;
    logic [SYM_W-1:0]         vid_sym;
    logic signed [DISP_W-1:0] vid_disp;
    logic [SYM_W-1:0]         aux_sym;

    lse_min_trans #(.W(PIX_W)) u_min_trans (
        .pix_i (pix_i),
        .qm_o  (qm)
    );

    lse_dc_balance #(.W(PIX_W), .DW(DISP_W)) u_dc_balance (
        .qm_i   (qm),
        .disp_i (st_q.disp),
        .sym_o  (vid_sym),
        .disp_o (vid_disp)
    );

    lse_aux_codes u_aux_codes (
        .period_i (period_i),
        .ctl_i    (ctl_i),
        .nib_i    (nib_i),
        .lane_i   (lane_i),
        .sym_o    (aux_sym)
    );

    always_comb begin
        st_d = st_q;
        if (period_i == PER_VIDEO) begin
            st_d.sym  = vid_sym;
            st_d.disp = vid_disp;
        end else begin
            st_d.sym  = aux_sym;
            st_d.disp = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sym  <= CTRL_CODE0;
            st_q.disp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sym_o = st_q.sym;

    // Packet characters are always exactly balanced (R3)
    p_pkt_balanced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_i == PER_PKT) |=> ($countones(sym_o) == 5));

    // XOR chain flagged by bit 8 when the pixel has few ones (R4)
    p_xor_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((period_i == PER_VIDEO) &&
         (($countones(pix_i) < 4) || (($countones(pix_i) == 4) && pix_i[0])))
        |=> sym_o[8]);

    // Disparity follows the imbalance of each video character sent (R5)
    p_disp_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_i == PER_VIDEO) |=>
        (int'(st_q.disp) == int'($past(st_q.disp)) + 2 * $countones(sym_o) - SYM_W));

    // Any non-video character leaves the disparity at zero (R6)
    p_disp_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_i != PER_VIDEO) |=> (st_q.disp == '0));

    // Lane 1 guard band value (R7)
    p_guard_lane1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((period_i == PER_GUARD) && (lane_i == LANE_W'(1))) |=> (sym_o == GB_LANE1));
endmodule

// File: tb/lane_symbol_encoder_tb_top.sv
module lane_symbol_encoder_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_ni;
    logic [1:0] period_i;
    logic [1:0] ctl_i;
    logic [3:0] nib_i;
    logic [7:0] pix_i;
    logic [1:0] lane_i;
    logic [9:0] sym_o;

    int checks = 0;
    int errors = 0;
    int mdisp  = 0;
    bit done   = 0;

    logic [9:0] ctl_tab [4]  = '{10'b1101010100, 10'b0010101011, 10'b0101010100, 10'b1010101011};
    logic [9:0] pkt_tab [16] = '{10'b1010011100, 10'b1001100011, 10'b1011100100, 10'b1011100010,
                                 10'b0101110001, 10'b0100011110, 10'b0110001110, 10'b0100111100,
                                 10'b1011001100, 10'b0100111001, 10'b0110011100, 10'b1011000110,
                                 10'b1010001110, 10'b1001110001, 10'b0101100011, 10'b1011000011};

    always #4 clk_i = ~clk_i;

    lane_symbol_encoder dut_i (
        .clk_i, .rst_ni, .period_i, .ctl_i, .nib_i, .pix_i, .lane_i, .sym_o
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sym_o=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] ref_video(input logic [7:0] d, inout int disp);
        int n1;
        int bal;
        bit xn;
        logic [8:0] m;
        logic [9:0] q;
        n1 = $countones(d);
        xn = (n1 > 4) || (n1 == 4 && !d[0]);
        m[0] = d[0];
        for (int i = 1; i < 8; i++) m[i] = xn ? ~(m[i-1] ^ d[i]) : (m[i-1] ^ d[i]);
        m[8] = !xn;
        bal = 2 * $countones(m[7:0]) - 8;
        if (disp == 0 || bal == 0)
            q = {~m[8], m[8], (m[8] ? m[7:0] : ~m[7:0])};
        else if ((disp > 0 && bal > 0) || (disp < 0 && bal < 0))
            q = {1'b1, m[8], ~m[7:0]};
        else
            q = {1'b0, m[8], m[7:0]};
        disp = disp + 2 * $countones(q) - 10;
        return q;
    endfunction

    task automatic step(input logic [1:0] per, input logic [1:0] c, input logic [3:0] n,
                        input logic [7:0] p, input logic [1:0] l, input string tag);
        logic [9:0] exp;
        string t;
        period_i = per; ctl_i = c; nib_i = n; pix_i = p; lane_i = l;
        case (per)
            2'b00: begin exp = ctl_tab[c]; mdisp = 0; t = "R2"; end
            2'b01: begin exp = pkt_tab[n]; mdisp = 0; t = "R3"; end
            2'b10: begin exp = ref_video(p, mdisp); t = "R5"; end
            default: begin exp = (l == 2'd1) ? 10'b0100110011 : 10'b1011001100; mdisp = 0; t = "R7"; end
        endcase
        if (tag != "") t = tag;
        @(negedge clk_i);
        check(t, sym_o, exp);
    endtask

    task automatic rnd_step(input string tag);
        step(2'($urandom), 2'($urandom), 4'($urandom), 8'($urandom), 2'($urandom), tag);
    endtask

    initial begin
        rst_ni = 1'b0; period_i = 2'b10; ctl_i = 0; nib_i = 0; pix_i = 8'hFF; lane_i = 0;
        @(negedge clk_i);
        check("R1", sym_o, 10'b1101010100);
        @(negedge clk_i);
        check("R1", sym_o, 10'b1101010100);
        rst_ni = 1'b1;
        mdisp = 0;
        step(2'b10, 0, 0, 8'h00, 0, "R1");
        // transition stage at the extremes
        step(2'b00, 0, 0, 0, 0, "");
        step(2'b10, 0, 0, 8'h00, 0, "R4");
        step(2'b10, 0, 0, 8'hFF, 0, "R4");
        step(2'b10, 0, 0, 8'h0F, 0, "R4");
        step(2'b10, 0, 0, 8'hF0, 0, "R4");
        step(2'b10, 0, 0, 8'h55, 0, "R4");
        for (int c = 0; c < 4; c++) step(2'b00, 2'(c), 0, 0, 0, "R2");
        for (int n = 0; n < 16; n++) step(2'b01, 0, 4'(n), 0, 0, "R3");
        for (int l = 0; l < 4; l++) step(2'b11, 0, 0, 0, 2'(l), "R7");
        // build disparity, then break with each non-video kind
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 5; j++) step(2'b10, 0, 0, 8'h01, 0, "R5");
            step(2'(k == 0 ? 0 : (k == 1 ? 1 : 3)), 0, 0, 0, 1, "");
            step(2'b10, 0, 0, 8'h01, 0, "R6");
            step(2'b10, 0, 0, 8'h10, 0, "R6");
        end
        // a new kind every clock
        for (int j = 0; j < 16; j++) step(2'(j % 4), 2'(j), 4'(j), 8'(j * 37), 2'(j), "R8");
        // junk on unused inputs
        for (int j = 0; j < 60; j++) begin
            step(2'b00, 2'(j), 4'($urandom), 8'($urandom), 2'($urandom), "R9");
            step(2'b01, 2'($urandom), 4'(j), 8'($urandom), 2'($urandom), "R9");
            step(2'b10, 2'($urandom), 4'($urandom), 8'($urandom), 2'($urandom), "R9");
            step(2'b11, 2'($urandom), 4'($urandom), 8'($urandom), 2'(j), "R9");
        end
        // long video runs with short breaks
        for (int j = 0; j < 2000; j++) begin
            if ((j % 40) < 34) step(2'b10, 2'($urandom), 4'($urandom), 8'($urandom), 2'($urandom), "R5");
            else rnd_step("");
        end
        for (int j = 0; j < 3000; j++) rnd_step("");
        // reset in the middle of video
        for (int j = 0; j < 7; j++) step(2'b10, 0, 0, 8'h03, 0, "R5");
        rst_ni = 1'b0;
        #1;
        check("R1", sym_o, 10'b1101010100);
        mdisp = 0;
        @(negedge clk_i);
        check("R1", sym_o, 10'b1101010100);
        rst_ni = 1'b1;
        step(2'b10, 0, 0, 8'h03, 0, "R1");
        step(2'b10, 0, 0, 8'h03, 0, "R5");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule